// File: doc/BRIEF.md
# Serial Register-Access Slave

This block lets an external controller read and write a small bank of control registers over a four-wire serial link: an active-low select, a serial clock, a data line into the block and a data line out of it. The registers drive the device's pin-control logic, so their contents are presented continuously on a flat parallel output.

The serial clock is never used as a clock. The select, the serial clock and the incoming data line pass through a chain of synchronizer flops clocked by the system clock. An edge detector then turns each rising or falling transition of the synchronized serial clock into a strobe one system cycle long. For this to work, the system clock has to run at least about five times faster than the serial clock, and ten times or more is the safer margin.

A frame is 24 bits, sent most significant bit first. It carries a 7-bit register address, then a direction flag, then a 16-bit data word. The block samples incoming bits on serial-clock rising edges and changes its output on falling edges.

Top module: `ser_regif_slave`

## Requirements
- R1: After reset every register reads zero on `reg_out` and `ser_dout` is low.
- R2: A frame carries, most significant bit first and sampled on serial-clock rising edges, a 7-bit address, a flag (0 = write, 1 = read) and a 16-bit data word. On a write frame, once the 24th bit is taken, register k on `reg_out[16k+15:16k]` holds the data word.
- R3: On a read frame, `ser_dout` shows bit 15 of the addressed register before the 9th rising edge. Each later bit appears after the next falling edge, so bit 15-n is valid before rising edge 9+n. A read leaves every register unchanged.
- R4: Releasing the select before the 24th bit ends the frame with no register written. The next selection starts a new frame from the first address bit.
- R5: If the select is released in the same system cycle that the 24th rising edge is detected, the release wins and no register is written.
- R6: With 4 registers, a write to an address of 4 or above changes nothing, and a read from such an address returns all zeros.
- R7: Bits clocked after the 24th while the select stays asserted are ignored: the register keeps the word from the first 24 bits and no second write happens.
- R8: `ser_dout` is low whenever the block is not selected and throughout the data phase of a write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run at least 5x, preferably 10x, the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low frame select from the controller |
| ser_clk | input | 1 | Serial clock from the controller, idle low |
| ser_din | input | 1 | Serial data into the block |
| ser_dout | output | 1 | Serial read data out of the block |
| reg_out | output | NREGS*DATA_W (64) | Register contents, register k at bits [16k+15:16k] |

## Verification
Two events can land in the same system cycle: the rising edge that completes the 24th bit, which commits a write, and the release of the select, which aborts the frame. The bench provokes this by changing the serial clock and the select at the same instant. Both then cross synchronizer chains of equal length and reach the sequencer together. The result is judged at the ports: the target register must keep its old value. A following ordinary frame to the same address must then commit, which shows that the lost write was the intended outcome and not a stuck sequencer.

// File: rtl/ser_regif_pkg.sv
package ser_regif_pkg;

    // Phase of the frame sequencer
    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,   // collecting address and direction flag
        PH_DATA = 2'd1,   // collecting or returning the data word
        PH_DONE = 2'd2    // frame complete, further bits ignored
    } phase_e;

endpackage

// File: rtl/ser_sync_edge.sv
module ser_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic sel_n,
    input  logic ser_din,
    output logic clk_rise,
    output logic clk_fall,
    output logic sel_act,
    output logic din_s
);

    // lane 0: serial clock, lane 1: select, lane 2: data
    typedef struct packed {
        logic [STAGES-1:0][2:0] chain;
        logic                   prev;
    } sync_st_t;

    sync_st_t sync_d, sync_q;
    logic [2:0] tail;

    always_comb begin
        sync_d          = sync_q;
        sync_d.chain[0] = {ser_din, sel_n, ser_clk};
        for (int i = 1; i < STAGES; i++) begin
            sync_d.chain[i] = sync_q.chain[i-1];
        end
        sync_d.prev = sync_q.chain[STAGES-1][0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                sync_q.chain[i] <= 3'b010;
            end
            sync_q.prev <= 1'b0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign tail     = sync_q.chain[STAGES-1];
    assign clk_rise = tail[0] & ~sync_q.prev;
    assign clk_fall = ~tail[0] & sync_q.prev;
    assign sel_act  = ~tail[1];
    assign din_s    = tail[2];

endmodule

// File: rtl/ser_frame_seq.sv
module ser_frame_seq
    import ser_regif_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_rise,
    input  logic              clk_fall,
    input  logic              sel_act,
    input  logic              din_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_active,
    output logic              ser_dout
);

    localparam int HDR_BITS   = ADDR_W + 1;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        phase_e              ph;
        logic [CNT_W-1:0]    cnt;
        logic [DATA_W-2:0]   in_sh;
        logic [DATA_W-1:0]   out_sh;
        logic                rd;
        logic [ADDR_W-1:0]   addr;
    } seq_st_t;

    seq_st_t seq_d, seq_q;
    logic [DATA_W-1:0] shifted;

    // incoming word with the current data bit appended
    assign shifted = {seq_q.in_sh, din_s};

    always_comb begin
        seq_d = seq_q;
        wr_en = 1'b0;
        if (!sel_act) begin
            // release aborts the frame and takes priority over any edge
            seq_d.ph  = PH_HDR;
            seq_d.cnt = '0;
            seq_d.rd  = 1'b0;
        end else begin
            unique case (seq_q.ph)
                PH_HDR: begin
                    if (clk_rise) begin
                        seq_d.in_sh = shifted[DATA_W-2:0];
                        seq_d.cnt   = seq_q.cnt + 1'b1;
                        if (seq_q.cnt == CNT_W'(HDR_BITS - 1)) begin
                            seq_d.ph   = PH_DATA;
                            seq_d.addr = shifted[ADDR_W:1];
                            if (shifted[0]) begin
                                seq_d.rd     = 1'b1;
                                seq_d.out_sh = rd_data;
                            end
                        end
                    end
                end
                PH_DATA: begin
                    if (clk_rise) begin
                        seq_d.in_sh = shifted[DATA_W-2:0];
                        seq_d.cnt   = seq_q.cnt + 1'b1;
                        if (seq_q.cnt == CNT_W'(FRAME_BITS - 1)) begin
                            seq_d.ph = PH_DONE;
                            wr_en    = ~seq_q.rd;
                        end
                    end else if (clk_fall && seq_q.rd &&
                                 seq_q.cnt >= CNT_W'(HDR_BITS + 1)) begin
                        seq_d.out_sh = {seq_q.out_sh[DATA_W-2:0], 1'b0};
                    end
                end
                default: begin
                    seq_d.ph = PH_DONE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.ph     <= PH_HDR;
            seq_q.cnt    <= '0;
            seq_q.in_sh  <= '0;
            seq_q.out_sh <= '0;
            seq_q.rd     <= 1'b0;
            seq_q.addr   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_addr   = shifted[ADDR_W:1];
    assign wr_addr   = seq_q.addr;
    assign wr_data   = shifted;
    assign rd_active = seq_q.rd;
    assign ser_dout  = seq_q.rd & seq_q.out_sh[DATA_W-1];

endmodule

// File: rtl/ser_reg_bank.sv
module ser_reg_bank #(
    parameter int NREGS  = 4,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    output logic [NREGS*DATA_W-1:0] regs_flat
);

    logic [NREGS-1:0][DATA_W-1:0] bank_d, bank_q;
    logic [NREGS-1:0]             hit;

    for (genvar k = 0; k < NREGS; k++) begin : g_reg
        assign hit[k] = wr_en && (wr_addr == ADDR_W'(k));
        assign regs_flat[k*DATA_W +: DATA_W] = bank_q[k];
    end

    always_comb begin
        bank_d  = bank_q;
        rd_data = '0;
        for (int k = 0; k < NREGS; k++) begin
            if (hit[k]) begin
                bank_d[k] = wr_data;
            end
            if (rd_addr == ADDR_W'(k)) begin
                rd_data = bank_q[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

endmodule

// File: rtl/ser_regif_slave.sv
module ser_regif_slave #(
    parameter int NREGS       = 4,
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_n,
    input  logic                    ser_clk,
    input  logic                    ser_din,
    output logic                    ser_dout,
    output logic [NREGS*DATA_W-1:0] reg_out
);

    logic              clk_rise;
    logic              clk_fall;
    logic              sel_act;
    logic              din_s;
    logic              wr_en;
    logic              rd_active;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    ser_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .sel_n    (sel_n),
        .ser_din  (ser_din),
        .clk_rise (clk_rise),
        .clk_fall (clk_fall),
        .sel_act  (sel_act),
        .din_s    (din_s)
    );

    ser_frame_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_rise  (clk_rise),
        .clk_fall  (clk_fall),
        .sel_act   (sel_act),
        .din_s     (din_s),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_active (rd_active),
        .ser_dout  (ser_dout)
    );

    ser_reg_bank #(
        .NREGS  (NREGS),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .regs_flat (reg_out)
    );

endmodule

// File: rtl/ser_regif_checker.sv
module ser_regif_checker #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sel_act,
    input logic         fall,
    input logic         rd_active,
    input logic         wr_en,
    input logic         ser_dout,
    input logic [W-1:0] reg_out
);

    // R8: deselection forces the output low from the next cycle
    p_idle_dout_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_act |=> !ser_dout);

    // R4: registers move only on a commit strobe
    p_hold_without_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reg_out));

    // R7: one commit per frame, never two in a row
    p_single_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R3: a read frame never commits
    p_read_no_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active |-> !wr_en);

    // R3: read output changes only after a falling edge
    p_dout_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && sel_act && !fall) |=> $stable(ser_dout));

endmodule

bind ser_regif_slave ser_regif_checker #(
    .W (NREGS * DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_act   (sel_act),
    .fall      (clk_fall),
    .rd_active (rd_active),
    .wr_en     (wr_en),
    .ser_dout  (ser_dout),
    .reg_out   (reg_out)
);

// File: tb/test_ser_regif_slave.sv
`timescale 1ns/1ps
module test_ser_regif_slave;

    localparam int NREGS = 4;
    localparam int DW    = 16;
    localparam int H     = 8;   // system cycles per serial half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_din = 1'b0;
    logic ser_dout;
    logic [NREGS*DW-1:0] reg_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [DW-1:0] model [NREGS];

    always #10 clk = ~clk;

    ser_regif_slave i_ser_regif_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .ser_clk  (ser_clk),
        .ser_din  (ser_din),
        .ser_dout (ser_dout),
        .reg_out  (reg_out)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model_flat();
        logic [63:0] f;
        for (int k = 0; k < NREGS; k++) f[k*DW +: DW] = model[k];
        return f;
    endfunction

    function automatic logic [15:0] pat(input int a, input int p);
        int v;
        v = (a * 'h1357 + p * 'h2468 + 1) ^ 'hA5A5;
        return v[15:0];
    endfunction

    // One frame; nbits < 24 aborts, > 24 sends extra bits; same_end drops select with last rise
    task automatic run_frame(input logic [6:0] a, input bit rw, input logic [15:0] dat,
                             input int nbits, input bit same_end, output logic [15:0] rd_val);
        logic [23:0] fr;
        fr = {a, rw, dat};
        rd_val = '0;
        sel_n = 1'b0;
        wait_clk(H);
        for (int i = 0; i < nbits; i++) begin
            ser_din = (i < 24) ? fr[23-i] : ~fr[i % 24];
            wait_clk(H);
            if (i >= 8 && i < 24) rd_val[23-i] = ser_dout;
            if (same_end && i == nbits - 1) begin
                ser_clk = 1'b1;
                sel_n   = 1'b1;
                wait_clk(H);
                ser_clk = 1'b0;
                wait_clk(2 * H);
                return;
            end
            ser_clk = 1'b1;
            wait_clk(H);
            ser_clk = 1'b0;
        end
        wait_clk(H);
        sel_n = 1'b1;
        wait_clk(2 * H);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv;
        for (int k = 0; k < NREGS; k++) model[k] = '0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        check("R1 reset registers", reg_out, 64'h0);
        check("R1 reset dout", {63'h0, ser_dout}, 64'h0);

        // sweep: every in-range address plus out-of-range ones, several patterns
        for (int p = 0; p < 3; p++) begin
            for (int a = 0; a < NREGS + 3; a++) begin
                int addr;
                addr = (a == NREGS + 2) ? 127 : a;
                run_frame(7'(addr), 1'b0, pat(addr, p), 24, 1'b0, rv);
                if (addr < NREGS) model[addr] = pat(addr, p);
                check(addr < NREGS ? "R2 write commit" : "R6 out-of-range write",
                      reg_out, model_flat());
                check("R8 dout low in write frame", {48'h0, rv}, 64'h0);
            end
            for (int a = 0; a < NREGS + 3; a++) begin
                int addr;
                addr = (a == NREGS + 2) ? 127 : a;
                run_frame(7'(addr), 1'b1, 16'hFFFF, 24, 1'b0, rv);
                check(addr < NREGS ? "R3 read data" : "R6 out-of-range read",
                      {48'h0, rv}, {48'h0, (addr < NREGS) ? model[addr] : 16'h0});
                check("R3 read leaves registers", reg_out, model_flat());
            end
        end

        // R4: aborted frames at several cut points
        foreach (model[k]) begin end
        for (int c = 0; c < 4; c++) begin
            int cut;
            cut = (c == 0) ? 1 : (c == 1) ? 8 : (c == 2) ? 13 : 23;
            run_frame(7'd1, 1'b0, 16'h0BAD, cut, 1'b0, rv);
            check("R4 abort no write", reg_out, model_flat());
        end
        run_frame(7'd1, 1'b0, 16'h1234, 24, 1'b0, rv);
        model[1] = 16'h1234;
        check("R4 fresh frame after abort", reg_out, model_flat());

        // R5: deselect together with the 24th rising edge
        run_frame(7'd3, 1'b0, 16'hDEAD, 24, 1'b1, rv);
        check("R5 deselect wins over commit", reg_out, model_flat());
        run_frame(7'd3, 1'b0, 16'hBEEF, 24, 1'b0, rv);
        model[3] = 16'hBEEF;
        check("R5 next frame commits", reg_out, model_flat());

        // R7: trailing bits beyond the frame
        run_frame(7'd2, 1'b0, 16'h5A3C, 30, 1'b0, rv);
        model[2] = 16'h5A3C;
        check("R7 extra bits ignored", reg_out, model_flat());
        run_frame(7'd2, 1'b1, 16'h0000, 30, 1'b0, rv);
        check("R7 read after extra bits", {48'h0, rv}, {48'h0, 16'h5A3C});

        // R8: idle output
        wait_clk(5);
        check("R8 dout low when deselected", {63'h0, ser_dout}, 64'h0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule